// File: doc/BRIEF.md
# Serial Flash Page-Program Receiver

This block is the page-program path of a serial flash controller. It watches the SPI pins (mode 0 or 3, data sampled on rising SCK), recognises the program opcode and a 24-bit address, and collects the data bytes that follow in a one-page buffer. A byte goes to the column given by the low address byte, and the column wraps inside the page. If more than a page of data arrives, later bytes overwrite the earliest ones, so the last page-worth received is kept.

When chip select rises exactly after a whole data byte, the block starts a self-timed program cycle. It walks the buffer from column 0 upward. For every loaded column it reads the old array byte and sends out a write of old AND new, so programming can only clear bits. A busy flag covers the program cycle, and any command started while busy is ignored. The SPI pins are sampled by the system clock and must be slow relative to it (SCK high and low each for at least two clock cycles).

The array write port is valid/ready. While `mem_wr_valid` is high and `mem_wr_ready` is low, the address and data are held unchanged. The walk only advances on a cycle with `mem_wr_ready` high, so back-pressure stretches the program cycle and loses no write. The read port is combinational and is addressed at the same location as the pending write.

Top module: `flash_pgm_buf`

## Requirements
- R1: A transaction is acted on only if its first byte is 8'h02. It must be followed by three address bytes, most significant first. Address bits 23..18 are ignored, bits 17..8 select the page and bits 7..0 give the starting column. Any other opcode causes no write and no busy.
- R2: While cs_n is low, one bit of mosi is taken at each rising sclk, most significant bit first, eight bits per byte.
- R3: Data byte k is placed at column (start + k) mod 256 of the selected page. Every array write has address bits 17..8 equal to the selected page. Only columns that received data are written.
- R4: When more than 256 data bytes arrive, each column holds the last byte written to it, so the final 256 bytes are programmed.
- R5: No write and no busy result if cs_n rises inside the opcode or address, after zero data bytes, or after a number of data bits that is not a multiple of 8.
- R6: Each write carries the bitwise AND of the old array byte and the buffered byte.
- R7: busy is low in the clock cycle after the one that first samples cs_n high, and high in the cycle after that. When no write is stalled, busy then stays high for exactly PROG_CYCLES cycles. Every write happens while busy is high.
- R8: A transaction whose cs_n fall comes while busy is high is ignored entirely, and its data never reaches the array.
- R9: A stalled write (valid high, ready low) keeps valid, address and data stable. Accepted writes go in strictly ascending address order.
- R10: After reset, busy and mem_wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| busy | output | 1 | Program cycle in progress |
| mem_rd_addr | output | ADDR_W | Array read address (location of the pending write) |
| mem_rd_data | input | 8 | Old array byte at mem_rd_addr, combinational |
| mem_wr_valid | output | 1 | Array write request |
| mem_wr_ready | input | 1 | Array accepts the write this cycle |
| mem_wr_addr | output | ADDR_W | Array write address |
| mem_wr_data | output | 8 | Array write data (old AND new) |

## Verification
The busy result is two clock edges behind the cs_n rise. The bench raises cs_n on a falling clock edge and samples busy on the next two falling edges: low on the first, high on the second. It then counts falling edges with busy high and expects exactly PROG_CYCLES. Array contents are only compared after busy has fallen, and writes are counted at the rising edge where valid and ready meet. A command that should have no effect is followed by a wait longer than a whole program cycle before the write count and page contents are checked.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DATA,
    ST_SKIP
  } fpb_state_e;
endpackage

// File: rtl/fpb_spi_rx.sv
module fpb_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       aligned,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  logic       sclk_q, cs_q;
  logic [6:0] shreg_q;
  logic [2:0] bitcnt_q;
  logic       sclk_rise;

  assign sclk_rise = sclk && !sclk_q;
  assign cs_fall   = !cs_n && cs_q;
  assign cs_rise   = cs_n && !cs_q;
  assign aligned   = (bitcnt_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      sclk_q   <= sclk;
      cs_q     <= cs_n;
      byte_stb <= 1'b0;
      if (cs_fall) begin
        bitcnt_q <= '0;
      end else if (!cs_n && sclk_rise) begin
        shreg_q  <= {shreg_q[5:0], mosi};
        bitcnt_q <= bitcnt_q + 3'd1;
        if (bitcnt_q == 3'd7) begin
          byte_stb <= 1'b1;
          byte_val <= {shreg_q, mosi};
        end
      end
    end
  end
endmodule

// File: rtl/fpb_cmd_ctrl.sv
module fpb_cmd_ctrl
  import fpb_pkg::*;
#(
  parameter int        COL_W  = 8,
  parameter int        PAGE_W = 10,
  parameter logic [7:0] OPCODE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              aligned,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic              busy,
  output logic              buf_we,
  output logic              buf_clr,
  output logic [COL_W-1:0]  buf_col,
  output logic [7:0]        buf_wdata,
  output logic              commit,
  output logic [PAGE_W-1:0] page
);
  fpb_state_e         state_q;
  logic [1:0]         adr_cnt_q;
  logic [15:0]        adr_sh_q;
  logic [COL_W-1:0]   col_q;
  logic               got_data_q;

  assign buf_we    = (state_q == ST_DATA) && byte_stb;
  assign buf_clr   = cs_fall && !busy;
  assign buf_col   = col_q;
  assign buf_wdata = byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      adr_cnt_q  <= '0;
      adr_sh_q   <= '0;
      col_q      <= '0;
      got_data_q <= 1'b0;
      commit     <= 1'b0;
      page       <= '0;
    end else begin
      commit <= 1'b0;
      if (cs_fall) begin
        state_q    <= busy ? ST_SKIP : ST_OPC;
        adr_cnt_q  <= '0;
        got_data_q <= 1'b0;
      end else if (cs_rise) begin
        if (state_q == ST_DATA && aligned && (got_data_q || byte_stb))
          commit <= 1'b1;
        state_q <= ST_IDLE;
      end else if (byte_stb) begin
        case (state_q)
          ST_OPC: state_q <= (byte_val == OPCODE) ? ST_ADR : ST_SKIP;
          ST_ADR: begin
            adr_sh_q  <= {adr_sh_q[7:0], byte_val};
            adr_cnt_q <= adr_cnt_q + 2'd1;
            if (adr_cnt_q == 2'd2) begin
              state_q <= ST_DATA;
              col_q   <= byte_val[COL_W-1:0];
              page    <= adr_sh_q[PAGE_W-1:0];
            end
          end
          ST_DATA: begin
            col_q      <= col_q + 1'b1;
            got_data_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpb_page_buf.sv
module fpb_page_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  input  logic [COL_W-1:0] rcol,
  output logic [7:0]       rdata,
  output logic             rloaded
);
  logic [7:0]            mem_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[wcol] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (clr)  mask_q <= '0;
    else if (we)   mask_q[wcol] <= 1'b1;
  end

  assign rdata   = mem_q[rcol];
  assign rloaded = mask_q[rcol];
endmodule

// File: rtl/fpb_prog_eng.sv
module fpb_prog_eng #(
  parameter int ADDR_W      = 18,
  parameter int COL_W       = 8,
  parameter int PROG_CYCLES = 1000,
  localparam int PAGE_W = ADDR_W - COL_W,
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        buf_data,
  input  logic              buf_loaded,
  output logic [COL_W-1:0]  buf_col,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  logic             walk_q;
  logic [COL_W-1:0] col_q;
  logic [TMR_W-1:0] tmr_q;
  logic             step;

  assign buf_col      = col_q;
  assign mem_rd_addr  = {page, col_q};
  assign mem_wr_addr  = {page, col_q};
  assign mem_wr_valid = walk_q && buf_loaded;
  assign mem_wr_data  = mem_rd_data & buf_data;
  assign step         = walk_q && (!buf_loaded || mem_wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      walk_q <= 1'b0;
      col_q  <= '0;
      tmr_q  <= '0;
    end else if (commit && !busy) begin
      busy   <= 1'b1;
      walk_q <= 1'b1;
      col_q  <= '0;
      tmr_q  <= '0;
    end else if (busy) begin
      if (tmr_q != TMR_W'(PROG_CYCLES)) tmr_q <= tmr_q + 1'b1;
      if (step) begin
        if (&col_q) walk_q <= 1'b0;
        else        col_q  <= col_q + 1'b1;
      end
      if (!walk_q && tmr_q >= TMR_W'(PROG_CYCLES - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_pgm_buf.sv
module flash_pgm_buf #(
  parameter int         ADDR_W      = 18,
  parameter int         PAGE_BYTES  = 256,
  parameter int         PROG_CYCLES = 1000,
  parameter logic [7:0] OPCODE      = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic              cs_fall, cs_rise, aligned, byte_stb;
  logic [7:0]        byte_val;
  logic              buf_we, buf_clr, commit;
  logic [COL_W-1:0]  wr_col, rd_col;
  logic [7:0]        buf_wdata, buf_rdata;
  logic              buf_loaded;
  logic [PAGE_W-1:0] cmd_page;

  fpb_spi_rx u_rx (
    .clk, .rst_n, .sclk, .cs_n, .mosi,
    .cs_fall, .cs_rise, .aligned, .byte_stb, .byte_val
  );

  fpb_cmd_ctrl #(.COL_W(COL_W), .PAGE_W(PAGE_W), .OPCODE(OPCODE)) u_ctrl (
    .clk, .rst_n, .cs_fall, .cs_rise, .aligned, .byte_stb, .byte_val,
    .busy, .buf_we, .buf_clr, .buf_col(wr_col), .buf_wdata,
    .commit, .page(cmd_page)
  );

  fpb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk, .rst_n, .clr(buf_clr), .we(buf_we), .wcol(wr_col),
    .wdata(buf_wdata), .rcol(rd_col), .rdata(buf_rdata), .rloaded(buf_loaded)
  );

  fpb_prog_eng #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk, .rst_n, .commit, .page(cmd_page), .buf_data(buf_rdata),
    .buf_loaded, .buf_col(rd_col), .busy, .mem_rd_addr, .mem_rd_data,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
  );
endmodule

// File: rtl/flash_pgm_buf_chk.sv
module flash_pgm_buf_chk #(
  parameter int ADDR_W      = 18,
  parameter int PAGE_W      = 10,
  parameter int PROG_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              busy,
  input logic [PAGE_W-1:0] page,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [7:0]        mem_rd_data,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [7:0]        mem_wr_data
);
  localparam int COL_W = ADDR_W - PAGE_W;
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_len <= 0;
    else if (!busy)            busy_len <= 0;
    else if (busy_len < 32'h7fff_ffff) busy_len <= busy_len + 1;
  end

  // R9: stalled write holds steady
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R9: accepted writes ascend
  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=>
      !mem_wr_valid || (mem_wr_addr > $past(mem_wr_addr)));

  // R6: write can only clear bits of the old byte
  a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && (mem_rd_addr == mem_wr_addr) |->
      ((mem_wr_data & ~mem_rd_data) == 8'h00));

  // R3: writes stay in the selected page
  a_r3_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr[ADDR_W-1:COL_W] == page));

  // R7: writes only inside the busy window
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> busy);

  // R7: busy window lasts at least PROG_CYCLES
  a_r7_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len >= PROG_CYCLES));

  // R5: busy only starts with chip select high
  a_r5_rise_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_n);
endmodule

bind flash_pgm_buf flash_pgm_buf_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .page(cmd_page),
  .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/flash_pgm_buf_tb_top.sv
module flash_pgm_buf_tb_top;
  localparam int ADDR_W = 18;
  localparam int PROG   = 300;
  // vector: {hi6, page10, col8, nbytes16, seed8, old8}
  localparam int NV = 4;
  localparam logic [55:0] VEC [NV] = '{
    {6'h00, 10'd3, 8'h00, 16'd256, 8'h5A, 8'hFF},
    {6'h2A, 10'd5, 8'hFA, 16'd10,  8'h11, 8'hF0},
    {6'h00, 10'd7, 8'h10, 16'd260, 8'hC3, 8'hFF},
    {6'h15, 10'd9, 8'h80, 16'd1,   8'h00, 8'hAA}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic busy, mem_wr_valid, mem_wr_ready;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;
  logic [7:0] fmem [4096];
  logic [7:0] nb [256];
  logic       ld [256];
  int total = 0, bad = 0, wr_cnt = 0, hi_bad = 0;
  int bit_limit = -1, bits_sent = 0;
  bit stall_mode = 1'b0;

  always #5 clk = ~clk;

  flash_pgm_buf #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) dut_i (
    .clk, .rst_n, .sclk, .cs_n, .mosi, .busy, .mem_rd_addr, .mem_rd_data,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
  );

  assign mem_rd_data = fmem[mem_rd_addr[11:0]];

  always @(posedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      fmem[mem_wr_addr[11:0]] <= mem_wr_data;
      wr_cnt <= wr_cnt + 1;
      if (mem_wr_addr[ADDR_W-1:12] != '0) hi_bad <= hi_bad + 1;
    end
  end

  always @(negedge clk) mem_wr_ready <= stall_mode ? ~mem_wr_ready : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 3);
  endfunction

  task automatic send_bit(input logic b);
    if (bit_limit >= 0 && bits_sent >= bit_limit) return;
    mosi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    bits_sent++;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) send_bit(v[b]);
  endtask

  // sends a command; raising cs_n leaves the bench on that negedge
  task automatic send_cmd(input logic [7:0] opc, input logic [23:0] addr,
                          input int n, input logic [7:0] seed, input int extra);
    bits_sent = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    send_byte(opc);
    send_byte(addr[23:16]);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    for (int i = 0; i < n; i++) send_byte(dat(seed, i));
    for (int i = 0; i < extra; i++) send_bit(1'b0);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic fill_page(input int pg, input logic [7:0] v);
    for (int c = 0; c < 256; c++) fmem[pg*256 + c] = v;
  endtask

  task automatic wait_idle();
    repeat (PROG + 20) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  function automatic int page_errs(input int pg, input int col, input int n,
                                   input logic [7:0] seed, input logic [7:0] old);
    int e = 0;
    for (int c = 0; c < 256; c++) begin nb[c] = 8'h00; ld[c] = 1'b0; end
    for (int i = 0; i < n; i++) begin
      nb[(col + i) % 256] = dat(seed, i);
      ld[(col + i) % 256] = 1'b1;
    end
    for (int c = 0; c < 256; c++)
      if (fmem[pg*256 + c] != (ld[c] ? (old & nb[c]) : old)) e++;
    return e;
  endfunction

  initial begin
    int w0, blen, e;
    for (int i = 0; i < 4096; i++) fmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy", int'(busy), 0);
    check(mem_wr_valid == 1'b0, "R10 valid", int'(mem_wr_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table-driven: R1 R2 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [9:0] pg; logic [7:0] col, seed, old; int n, exp_w;
      pg = VEC[v][49:40]; col = VEC[v][39:32]; n = int'(VEC[v][31:16]);
      seed = VEC[v][15:8]; old = VEC[v][7:0];
      fill_page(int'(pg), old);
      w0 = wr_cnt;
      send_cmd(8'h02, {VEC[v][55:50], pg, col}, n, seed, 0);
      @(negedge clk);
      check(busy == 1'b0, "R7 busy low one cycle after cs rise", int'(busy), 0);
      @(negedge clk);
      check(busy == 1'b1, "R7 busy high two cycles after cs rise", int'(busy), 1);
      blen = 0;
      while (busy && blen < 100000) begin blen++; @(negedge clk); end
      check(blen == PROG, "R7 busy length", blen, PROG);
      exp_w = (n > 256) ? 256 : n;
      check(wr_cnt - w0 == exp_w, "R3 R4 write count", wr_cnt - w0, exp_w);
      e = page_errs(int'(pg), int'(col), n, seed, old);
      check(e == 0, "R1 R2 R3 R4 R6 page contents", e, 0);
    end
    check(hi_bad == 0, "R1 upper address bits ignored", hi_bad, 0);

    // R1: wrong opcode
    w0 = wr_cnt;
    send_cmd(8'h03, {6'h0, 10'd2, 8'h00}, 4, 8'h00, 0);
    wait_idle();
    check(wr_cnt == w0, "R1 other opcode no write", wr_cnt - w0, 0);

    // R5: cs rises mid byte
    w0 = wr_cnt;
    send_cmd(8'h02, {6'h0, 10'd4, 8'h00}, 3, 8'h00, 3);
    @(negedge clk); @(negedge clk);
    check(busy == 1'b0, "R5 partial byte no busy", int'(busy), 0);
    wait_idle();
    check(wr_cnt == w0, "R5 partial byte no write", wr_cnt - w0, 0);

    // R5: cs rises inside address
    w0 = wr_cnt;
    bit_limit = 20;
    send_cmd(8'h02, {6'h0, 10'd4, 8'h00}, 2, 8'h00, 0);
    bit_limit = -1;
    wait_idle();
    check(wr_cnt == w0, "R5 cut in address no write", wr_cnt - w0, 0);

    // R5: zero data bytes
    w0 = wr_cnt;
    send_cmd(8'h02, {6'h0, 10'd4, 8'h00}, 0, 8'h00, 0);
    wait_idle();
    check(wr_cnt == w0, "R5 zero data no write", wr_cnt - w0, 0);
    check(page_errs(4, 0, 0, 8'h00, 8'hFF) == 0, "R5 page untouched",
          page_errs(4, 0, 0, 8'h00, 8'hFF), 0);

    // R8: command during busy ignored
    fill_page(6, 8'hFF);
    fill_page(11, 8'hFF);
    w0 = wr_cnt;
    send_cmd(8'h02, {6'h0, 10'd6, 8'h00}, 4, 8'h33, 0);
    repeat (3) @(negedge clk);
    send_cmd(8'h02, {6'h0, 10'd11, 8'h00}, 2, 8'h00, 0);
    wait_idle();
    check(wr_cnt - w0 == 4, "R8 only first command written", wr_cnt - w0, 4);
    e = page_errs(11, 0, 0, 8'h00, 8'hFF);
    check(e == 0, "R8 page of ignored command untouched", e, 0);

    // R9: back-pressure on the write port
    fill_page(12, 8'h7E);
    w0 = wr_cnt;
    stall_mode = 1'b1;
    send_cmd(8'h02, {6'h0, 10'd12, 8'h00}, 20, 8'h9C, 0);
    wait_idle();
    stall_mode = 1'b0;
    check(wr_cnt - w0 == 20, "R9 stalled write count", wr_cnt - w0, 20);
    e = page_errs(12, 0, 20, 8'h9C, 8'h7E);
    check(e == 0, "R9 R6 stalled page contents", e, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule